// File: doc/BRIEF.md
# Arm Submodule Gating Rotator

This block sits between a phase-level pattern sequencer and the eight half-bridge submodules of one converter leg. There are four submodules in the upper arm and four in the lower arm. Each cycle it takes a phase level from 0 to 4 and works out how many submodules each arm inserts. The upper arm takes the level itself and the lower arm takes four minus the level, so one leg always has four submodules in conduction. The block then drives the top and bottom switch of every submodule, with a programmable blanking interval at each change of state.

Capacitor balance is kept without any voltage measurement. The inserted count is first placed on logical gate channels, lowest channel first. Those channels are then mapped onto the physical submodules through a rotation offset. A cycle-start strobe from the sequencer advances that offset by one position. Over four fundamental cycles every submodule carries each channel's duty once, so its net charge over that span is zero. Both arms share the same offset.

Top module: `arm_gate_rotator`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) turns every top switch off and every bottom switch on, which bypasses all submodules. It also sets the rotation offset to 0.
- R2: A level k from 0 to 4 inserts exactly k upper-arm submodules and 4-k lower-arm submodules. With a dead time of 0, the switch outputs reach the new state on the first clock edge after the level is applied.
- R3: Any level value above 4 is handled exactly as level 4.
- R4: For an arm count c, gate channels 1 through c are asserted. With offset r, channel j (1..4) drives submodule ((j-1+r) mod 4)+1. In every 4-bit output vector, bit 0 is submodule 1 and bit 3 is submodule 4.
- R5: The rotation offset advances by one, wrapping from 3 to 0, at every clock edge where `cycleStart` is high, and holds otherwise. The new offset shows at the outputs one edge later, and both arms use it.
- R6: The top and bottom switch of a submodule are never both on.
- R7: With dead time D > 0, a change in a submodule's commanded state turns both of its switches off for exactly D clock cycles, after which the new switch turns on. A submodule whose commanded state does not change keeps its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| level | input | 3 | Phase level; upper inserted count |
| cycleStart | input | 1 | Fundamental-cycle start strobe |
| deadTime | input | 8 | Blanking interval in clock cycles |
| upperTop | output | 4 | Upper arm top switches (1 = on) |
| upperBot | output | 4 | Upper arm bottom switches (1 = on) |
| lowerTop | output | 4 | Lower arm top switches (1 = on) |
| lowerBot | output | 4 | Lower arm bottom switches (1 = on) |

## Verification
A wrong rotation offset appears at the ports two edges after the strobe as an inserted mask shifted to the wrong submodules. The vector walk steps the offset through all four positions and across the wrap, so such an error is caught at the next check. A wrong dead-time counter shows up as a blanking window that is one cycle too short or too long. The bench catches this by sampling the changing pair on every cycle of the window, while a neighbouring pair that does not change must stay steady.

// File: rtl/agr_pkg.sv
package agr_pkg;
  localparam int SM_PER_ARM = 4;
  localparam int OFS_W = $clog2(SM_PER_ARM);
  localparam int CNT_W = $clog2(SM_PER_ARM + 1);

  // control-to-datapath strobes and counts
  typedef struct packed {
    logic             advance;
    logic [OFS_W-1:0] offset;
    logic [CNT_W-1:0] upCount;
    logic [CNT_W-1:0] loCount;
  } agr_ctl_t;
endpackage

// File: rtl/agr_ctrl.sv
module agr_ctrl
  import agr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] level,
  input  logic             cycleStart,
  output agr_ctl_t         ctl
);
  logic [OFS_W-1:0] rotOfs;
  logic [CNT_W-1:0] clampLvl;

  always_ff @(posedge clk) begin
    if (rst) rotOfs <= '0;
    else if (cycleStart) rotOfs <= rotOfs + 1'b1;
  end

  always_comb begin
    clampLvl    = (level > CNT_W'(SM_PER_ARM)) ? CNT_W'(SM_PER_ARM) : level;
    ctl.advance = cycleStart;
    ctl.offset  = rotOfs;
    ctl.upCount = clampLvl;
    ctl.loCount = CNT_W'(SM_PER_ARM) - clampLvl;
  end
endmodule

// File: rtl/agr_deadband.sv
module agr_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            want,
  input  logic [DT_W-1:0] deadTime,
  output logic            swTop,
  output logic            swBot
);
  logic            applied;
  logic [DT_W-1:0] blankCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      applied  <= 1'b0;
      blankCnt <= '0;
      swTop    <= 1'b0;
      swBot    <= 1'b1;
    end else if (want != applied) begin
      applied <= want;
      if (deadTime == '0) begin
        swTop    <= want;
        swBot    <= ~want;
        blankCnt <= '0;
      end else begin
        swTop    <= 1'b0;
        swBot    <= 1'b0;
        blankCnt <= deadTime;
      end
    end else if (blankCnt != '0) begin
      blankCnt <= blankCnt - 1'b1;
      if (blankCnt == DT_W'(1)) begin
        swTop <= applied;
        swBot <= ~applied;
      end
    end
  end
endmodule

// File: rtl/agr_datapath.sv
module agr_datapath
  import agr_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  agr_ctl_t              ctl,
  input  logic [DT_W-1:0]       deadTime,
  output logic [SM_PER_ARM-1:0] upperTop,
  output logic [SM_PER_ARM-1:0] upperBot,
  output logic [SM_PER_ARM-1:0] lowerTop,
  output logic [SM_PER_ARM-1:0] lowerBot
);
  localparam int ARMS = 2;

  logic [SM_PER_ARM-1:0] topV [ARMS];
  logic [SM_PER_ARM-1:0] botV [ARMS];

  for (genvar arm = 0; arm < ARMS; arm++) begin : g_arm
    logic [CNT_W-1:0] armCount;
    assign armCount = (arm == 0) ? ctl.upCount : ctl.loCount;
    for (genvar sm = 0; sm < SM_PER_ARM; sm++) begin : g_sm
      logic [OFS_W-1:0] chanIdx;
      logic             wantIns;
      // channel that lands on this submodule under the current rotation
      assign chanIdx = OFS_W'(sm) - ctl.offset;
      assign wantIns = CNT_W'(chanIdx) < armCount;
      agr_deadband #(.DT_W(DT_W)) u_db (
        .clk     (clk),
        .rst     (rst),
        .want    (wantIns),
        .deadTime(deadTime),
        .swTop   (topV[arm][sm]),
        .swBot   (botV[arm][sm])
      );
    end
  end

  assign upperTop = topV[0];
  assign upperBot = botV[0];
  assign lowerTop = topV[1];
  assign lowerBot = botV[1];
endmodule

// File: rtl/arm_gate_rotator.sv
module arm_gate_rotator
  import agr_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CNT_W-1:0]      level,
  input  logic                  cycleStart,
  input  logic [DT_W-1:0]       deadTime,
  output logic [SM_PER_ARM-1:0] upperTop,
  output logic [SM_PER_ARM-1:0] upperBot,
  output logic [SM_PER_ARM-1:0] lowerTop,
  output logic [SM_PER_ARM-1:0] lowerBot
);
  agr_ctl_t         ctlBus;
  logic [OFS_W-1:0] rotOffset;

  assign rotOffset = ctlBus.offset;

  agr_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .level     (level),
    .cycleStart(cycleStart),
    .ctl       (ctlBus)
  );

  agr_datapath #(.DT_W(DT_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctlBus),
    .deadTime(deadTime),
    .upperTop(upperTop),
    .upperBot(upperBot),
    .lowerTop(lowerTop),
    .lowerBot(lowerBot)
  );
endmodule

// File: rtl/agr_checker.sv
module agr_checker
  import agr_pkg::*;
#(
  parameter int DT_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cycleStart,
  input logic [DT_W-1:0]       deadTime,
  input logic [OFS_W-1:0]      rotOffset,
  input logic [SM_PER_ARM-1:0] upperTop,
  input logic [SM_PER_ARM-1:0] upperBot,
  input logic [SM_PER_ARM-1:0] lowerTop,
  input logic [SM_PER_ARM-1:0] lowerBot
);
  logic prevRst;

  always_ff @(posedge clk) begin
    prevRst <= rst;
    if (rst && prevRst) begin
      AST_RESET_BYPASS: assert (upperTop == '0 && lowerTop == '0 &&
                                upperBot == '1 && lowerBot == '1) else $error("reset state"); // R1
    end
  end

  AST_NEVER_BOTH_ON: assert property (@(posedge clk) disable iff (rst)
    ((upperTop & upperBot) == '0) && ((lowerTop & lowerBot) == '0)); // R6

  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (rst)
    cycleStart |=> rotOffset == OFS_W'($past(rotOffset) + 1'b1)); // R5

  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cycleStart |=> $stable(rotOffset)); // R5

  AST_UPPER_BLANK: assert property (@(posedge clk) disable iff (rst)
    ($past(deadTime) != '0) |-> ((upperTop & ~$past(upperTop) & $past(upperBot)) == '0)); // R7

  AST_LOWER_BLANK: assert property (@(posedge clk) disable iff (rst)
    ($past(deadTime) != '0) |-> ((lowerTop & ~$past(lowerTop) & $past(lowerBot)) == '0)); // R7
endmodule

bind arm_gate_rotator agr_checker #(.DT_W(DT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cycleStart(cycleStart),
  .deadTime  (deadTime),
  .rotOffset (rotOffset),
  .upperTop  (upperTop),
  .upperBot  (upperBot),
  .lowerTop  (lowerTop),
  .lowerBot  (lowerBot)
);

// File: tb/arm_gate_rotator_tb.sv
module arm_gate_rotator_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] level;
  logic       cycleStart;
  logic [7:0] deadTime;
  logic [3:0] upperTop, upperBot, lowerTop, lowerBot;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  arm_gate_rotator u_dut (
    .clk(clk), .rst(rst), .level(level), .cycleStart(cycleStart),
    .deadTime(deadTime), .upperTop(upperTop), .upperBot(upperBot),
    .lowerTop(lowerTop), .lowerBot(lowerBot)
  );

  // {strobe, level, upper inserted mask, lower inserted mask}; bit0 = submodule 1
  localparam logic [11:0] VEC [16] = '{
    {1'b0, 3'd0, 4'b0000, 4'b1111},
    {1'b0, 3'd1, 4'b0001, 4'b0111},
    {1'b0, 3'd2, 4'b0011, 4'b0011},
    {1'b0, 3'd3, 4'b0111, 4'b0001},
    {1'b0, 3'd4, 4'b1111, 4'b0000},
    {1'b1, 3'd1, 4'b0010, 4'b1110},
    {1'b0, 3'd2, 4'b0110, 4'b0110},
    {1'b0, 3'd3, 4'b1110, 4'b0010},
    {1'b1, 3'd1, 4'b0100, 4'b1101},
    {1'b0, 3'd2, 4'b1100, 4'b1100},
    {1'b0, 3'd3, 4'b1101, 4'b0100},
    {1'b1, 3'd1, 4'b1000, 4'b1011},
    {1'b0, 3'd3, 4'b1011, 4'b1000},
    {1'b1, 3'd2, 4'b0011, 4'b0011},
    {1'b0, 3'd7, 4'b1111, 4'b0000},
    {1'b0, 3'd5, 4'b1111, 4'b0000}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic checkArms(input string req, input logic [3:0] upM, input logic [3:0] loM);
    check({req, " upper"}, {upperTop, upperBot}, {upM, ~upM});
    check({req, " lower"}, {lowerTop, lowerBot}, {loM, ~loM});
  endtask

  task automatic runTests();
    rst = 1'b1; level = 3'd4; cycleStart = 1'b0; deadTime = 8'd0;
    repeat (3) @(negedge clk);
    checkArms("R1 reset bypass", 4'b0000, 4'b0000);
    rst = 1'b0;

    // R2 R3 R4 R5: vector walk over levels and all rotation offsets
    for (int i = 0; i < 16; i++) begin
      level = VEC[i][10:8];
      cycleStart = VEC[i][11];
      @(negedge clk);
      cycleStart = 1'b0;
      repeat (2) @(negedge clk);
      checkArms($sformatf("R2/R4/R5 vec%0d", i), VEC[i][7:4], VEC[i][3:0]);
    end

    // R5: no strobe, offset holds over many cycles
    level = 3'd2;
    repeat (20) @(negedge clk);
    checkArms("R5 hold", 4'b0011, 4'b0011);

    // R1: reset clears the offset
    cycleStart = 1'b1;
    @(negedge clk);
    cycleStart = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    level = 3'd1;
    repeat (3) @(negedge clk);
    checkArms("R1 offset cleared", 4'b0001, 4'b0111);

    // R7: dead time of 3 cycles
    rst = 1'b1; level = 3'd0; deadTime = 8'd3;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    checkArms("R7 settled", 4'b0000, 4'b1111);
    level = 3'd1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check($sformatf("R7 upper SM1 blank c%0d", c), {6'd0, upperTop[0], upperBot[0]}, 8'b00);
      check($sformatf("R7 lower SM4 blank c%0d", c), {6'd0, lowerTop[3], lowerBot[3]}, 8'b00);
      check($sformatf("R7 upper SM2 steady c%0d", c), {6'd0, upperTop[1], upperBot[1]}, 8'b01);
    end
    @(negedge clk);
    check("R7 upper SM1 on", {6'd0, upperTop[0], upperBot[0]}, 8'b10);
    check("R7 lower SM4 off", {6'd0, lowerTop[3], lowerBot[3]}, 8'b01);
    check("R6 no pair both on", {upperTop & upperBot, lowerTop & lowerBot}, 8'h00);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule